// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block judges a single memory access against a table of eight protection entries. Each entry has an 8-bit configuration byte and an address register. It reports whether the access may proceed and which entry, if any, made the decision. The access is described by a byte address, a kind (load, store-class write or instruction fetch) and the effective privilege of the requester.

The checker is purely combinational. The core places it between address generation and the memory request, and it feeds it the live contents of its protection registers. The block does not store the registers, apply lock rules to writes, check memory attributes or raise traps. Those jobs belong to the surrounding logic.

Every entry runs one of four match modes: disabled, top-of-range, 4-byte aligned, or power-of-two aligned. All entries evaluate in parallel. A fixed priority then picks the lowest-numbered entry that hits, and a permission stage applies that entry's rights. Machine mode is exempt from an entry's rights unless that entry is locked.

Top module: `pmp_access_check`

## Requirements
- R1: An entry whose mode field (config bits 4:3) is 0 never matches any address.
- R2: Mode 1 (top-of-range) matches when the previous entry's address register is less than or equal to the access word address, and the access word address is strictly less than this entry's register. The lower bound for entry 0 is zero. The access word address is the byte address shifted right by 2, and address registers hold word addresses.
- R3: Mode 2 matches exactly the 4 bytes whose word address equals the register.
- R4: Mode 3 treats t trailing ones in the register as a naturally aligned region of 2^(t+3) bytes. The register bits above those t+1 low bits select the base.
- R5: When several entries match, the lowest-numbered one decides. `hit_any` is 1 and `hit_idx` gives its number. With no match, `hit_any` is 0 and `hit_idx` is 0.
- R6: With an unlocked matching entry (config bit 7 = 0), machine privilege (`acc_priv` = 3) is always allowed. Any other privilege value needs the permission bit for the access kind.
- R7: With a locked matching entry (config bit 7 = 1), machine privilege also needs the permission bit.
- R8: `acc_kind` 0 is a read and needs config bit 0. Value 1 is a write and needs bit 1. Value 2 is a fetch and needs bit 2. Value 3 is always denied, at every privilege.
- R9: With no matching entry, the result depends on the table. If at least one entry is not disabled, machine privilege is allowed and all other privileges are denied. If every entry is disabled, every privilege is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_addr | input | 34 | Byte address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 invalid |
| acc_priv | input | 2 | Effective privilege, 3 is machine |
| ent_cfg | input | 64 | Entry i configuration byte at bits 8i+7:8i |
| ent_addr | input | 256 | Entry i word-address register at bits 32i+31:32i |
| acc_ok | output | 1 | Access allowed |
| hit_any | output | 1 | Some entry matched |
| hit_idx | output | 3 | Number of the deciding entry |

## Verification
Two functions can decide the same access at once: a top-of-range match and a power-of-two or 4-byte match from another entry. The bench provokes this by placing overlapping regions in entries with different rights. It checks that the rights of the lower number win, even when the higher entry would grant the access. A second collision is a locked entry seen by a machine-mode requester. Here the lock rule and the machine exemption meet in one evaluation. The bench judges it by setting up the same region with lock off and then with lock on, and expecting opposite verdicts.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    localparam logic [1:0] PRIV_MACH = 2'b11;

    typedef struct packed {
        logic        lock;
        logic [1:0]  spare;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } ent_cfg_t;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_chk_pkg::*;
#(
    parameter int AR_W = 32
) (
    input  ent_cfg_t          cfg,
    input  logic [AR_W-1:0]   reg_addr,
    input  logic [AR_W-1:0]   prev_addr,
    input  logic [AR_W-1:0]   word_addr,
    output logic              hit
);

    logic [AR_W-1:0] span;
    logic [AR_W-1:0] keep_mask;

    always_comb begin
        span      = reg_addr ^ (reg_addr + {{(AR_W-1){1'b0}}, 1'b1});
        keep_mask = ~span;
        unique case (cfg.mode)
            MODE_OFF:   hit = 1'b0;
            MODE_TOR:   hit = (word_addr >= prev_addr) && (word_addr < reg_addr);
            MODE_NA4:   hit = (word_addr == reg_addr);
            MODE_NAPOT: hit = ((word_addr & keep_mask) == (reg_addr & keep_mask));
            default:    hit = 1'b0;
        endcase
    end

    always_comb begin
        if (!$isunknown(cfg) && cfg.mode == MODE_OFF) begin
            // R1
            off_silent_chk: assert (!hit);
        end
        if (!$isunknown(cfg) && cfg.mode == MODE_TOR && hit) begin
            // R2
            tor_upper_chk: assert (word_addr < reg_addr);
        end
    end

endmodule

// File: rtl/pmp_first_hit.sv
module pmp_first_hit #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     hits,
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx
);

    logic [N-1:0] below;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) hit_idx = i[IDX_W-1:0];
        end
        hit_any = |hits;
        below   = (N'(1) << hit_idx) - N'(1);
    end

    always_comb begin
        if (!$isunknown(hits) && hit_any) begin
            // R5
            winner_set_chk: assert (hits[hit_idx]);
            // R5
            none_lower_chk: assert ((hits & below) == '0);
        end
    end

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
    import pmp_chk_pkg::*;
(
    input  ent_cfg_t   sel_cfg,
    input  logic       hit_any,
    input  logic       any_active,
    input  acc_kind_e  kind,
    input  logic [1:0] priv,
    output logic       ok
);

    logic is_mach;
    logic right;

    always_comb begin
        is_mach = (priv == PRIV_MACH);
        unique case (kind)
            ACC_READ:  right = sel_cfg.r;
            ACC_WRITE: right = sel_cfg.w;
            ACC_FETCH: right = sel_cfg.x;
            default:   right = 1'b0;
        endcase
        if (kind == ACC_BAD)  ok = 1'b0;
        else if (hit_any)     ok = (is_mach && !sel_cfg.lock) || right;
        else                  ok = is_mach || !any_active;
    end

endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
    import pmp_chk_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int PA_W  = 34
) (
    input  logic [PA_W-1:0]                    acc_addr,
    input  logic [1:0]                         acc_kind,
    input  logic [1:0]                         acc_priv,
    input  logic [N_ENT*8-1:0]                 ent_cfg,
    input  logic [N_ENT*(PA_W-2)-1:0]          ent_addr,
    output logic                               acc_ok,
    output logic                               hit_any,
    output logic [((N_ENT>1)?$clog2(N_ENT):1)-1:0] hit_idx
);

    localparam int AR_W  = PA_W - 2;
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    ent_cfg_t           cfgs  [N_ENT];
    logic [AR_W-1:0]    regs  [N_ENT];
    logic [AR_W-1:0]    prevs [N_ENT];
    logic [N_ENT-1:0]   hits;
    logic [N_ENT-1:0]   active;
    logic [AR_W-1:0]    word_addr;
    logic               any_active;
    ent_cfg_t           sel_cfg;
    logic               spare_unused;

    assign word_addr = acc_addr[PA_W-1:2];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign cfgs[i]   = ent_cfg_t'(ent_cfg[8*i +: 8]);
        assign regs[i]   = ent_addr[AR_W*i +: AR_W];
        assign active[i] = (cfgs[i].mode != MODE_OFF);
        if (i == 0) begin : g_base
            assign prevs[i] = '0;
        end else begin : g_chain
            assign prevs[i] = ent_addr[AR_W*(i-1) +: AR_W];
        end
        pmp_region_match #(.AR_W(AR_W)) u_match (
            .cfg       (cfgs[i]),
            .reg_addr  (regs[i]),
            .prev_addr (prevs[i]),
            .word_addr (word_addr),
            .hit       (hits[i])
        );
    end

    assign any_active   = |active;
    assign spare_unused = ^{acc_addr[1:0], ent_cfg};

    pmp_first_hit #(.N(N_ENT), .IDX_W(IDX_W)) u_pick (
        .hits    (hits),
        .hit_any (hit_any),
        .hit_idx (hit_idx)
    );

    assign sel_cfg = cfgs[hit_idx];

    pmp_perm_eval u_perm (
        .sel_cfg    (sel_cfg),
        .hit_any    (hit_any),
        .any_active (any_active),
        .kind       (acc_kind_e'(acc_kind)),
        .priv       (acc_priv),
        .ok         (acc_ok)
    );

    always_comb begin
        if (!$isunknown({acc_kind, acc_priv, ent_cfg, ent_addr, acc_addr})) begin
            if (hit_any && acc_priv == PRIV_MACH && !sel_cfg.lock && acc_kind != 2'd3) begin
                // R6
                mach_exempt_chk: assert (acc_ok);
            end
            if (!hit_any && any_active && acc_priv != PRIV_MACH) begin
                // R9
                nomatch_deny_chk: assert (!acc_ok);
            end
            if (acc_kind == 2'd3) begin
                // R8
                bad_kind_chk: assert (!acc_ok);
            end
        end
    end

endmodule

// File: tb/pmp_access_check_test.sv
module pmp_access_check_test;

    logic        clk = 1'b0;
    logic [33:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_priv = '0;
    logic [63:0] ent_cfg  = '0;
    logic [255:0] ent_addr = '0;
    logic        acc_ok;
    logic        hit_any;
    logic [2:0]  hit_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pmp_access_check uut (
        .acc_addr (acc_addr),
        .acc_kind (acc_kind),
        .acc_priv (acc_priv),
        .ent_cfg  (ent_cfg),
        .ent_addr (ent_addr),
        .acc_ok   (acc_ok),
        .hit_any  (hit_any),
        .hit_idx  (hit_idx)
    );

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_FE = 2'd2, K_BAD = 2'd3;
    localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;

    task automatic clear_all();
        @(negedge clk);
        ent_cfg  = '0;
        ent_addr = '0;
    endtask

    // cfg byte: bit7 lock, bits4:3 mode, bit2 X, bit1 W, bit0 R
    task automatic set_ent(input int i, input logic lk, input logic [1:0] md,
                           input logic [2:0] xwr, input logic [31:0] wa);
        @(negedge clk);
        ent_cfg[8*i +: 8]   = {lk, 2'b00, md, xwr};
        ent_addr[32*i +: 32] = wa;
    endtask

    task automatic probe(input string tag, input logic [1:0] k, input logic [1:0] p,
                         input logic [33:0] a, input logic e_ok, input logic e_hit,
                         input logic [2:0] e_idx);
        @(negedge clk);
        acc_kind = k;
        acc_priv = p;
        acc_addr = a;
        #2;
        n_chk++;
        if (acc_ok !== e_ok || hit_any !== e_hit || (e_hit && hit_idx !== e_idx)) begin
            n_fail++;
            $display("FAIL %s: ok/hit/idx got %0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, acc_ok, hit_any, hit_idx, e_ok, e_hit, e_idx);
        end
    endtask

    task automatic t_all_off();
        clear_all();
        probe("R9 all off user read", K_RD, P_U, 34'h1000, 1'b1, 1'b0, 3'd0);
        probe("R1 R5 idle idx", K_WR, P_S, 34'h0, 1'b1, 1'b0, 3'd0);
        n_chk++;
        if (hit_idx !== 3'd0) begin
            n_fail++;
            $display("FAIL R5 idle idx got %0d expected 0", hit_idx);
        end
    endtask

    task automatic t_na4();
        clear_all();
        set_ent(2, 1'b0, 2'd2, 3'b001, 32'h400);
        probe("R3 na4 read", K_RD, P_U, 34'h1003, 1'b1, 1'b1, 3'd2);
        probe("R8 na4 write no W", K_WR, P_U, 34'h1000, 1'b0, 1'b1, 3'd2);
        probe("R3 R9 na4 next word S", K_RD, P_S, 34'h1004, 1'b0, 1'b0, 3'd0);
        probe("R9 nomatch machine", K_RD, P_M, 34'h1004, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_tor();
        clear_all();
        set_ent(0, 1'b0, 2'd1, 3'b100, 32'h800);
        set_ent(1, 1'b0, 2'd1, 3'b011, 32'hC00);
        probe("R2 tor base zero", K_FE, P_U, 34'h0, 1'b1, 1'b1, 3'd0);
        probe("R2 tor top-1", K_FE, P_U, 34'h1FFC, 1'b1, 1'b1, 3'd0);
        probe("R2 tor chained lower", K_RD, P_U, 34'h2000, 1'b1, 1'b1, 3'd1);
        probe("R8 fetch no X", K_FE, P_S, 34'h2000, 1'b0, 1'b1, 3'd1);
        probe("R2 tor above", K_RD, P_U, 34'h3000, 1'b0, 1'b0, 3'd0);
        set_ent(1, 1'b0, 2'd0, 3'b011, 32'hC00);
        probe("R1 off entry no hit", K_RD, P_U, 34'h2000, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_napot();
        clear_all();
        set_ent(3, 1'b0, 2'd3, 3'b001, 32'h2007);
        set_ent(4, 1'b0, 2'd3, 3'b010, 32'h2400);
        probe("R4 napot64 base", K_RD, P_U, 34'h8000, 1'b1, 1'b1, 3'd3);
        probe("R4 napot64 last", K_RD, P_U, 34'h803C, 1'b1, 1'b1, 3'd3);
        probe("R4 napot64 past", K_RD, P_U, 34'h8040, 1'b0, 1'b0, 3'd0);
        probe("R4 napot8 in", K_WR, P_S, 34'h9004, 1'b1, 1'b1, 3'd4);
        probe("R4 napot8 past", K_WR, P_S, 34'h9008, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_priority();
        clear_all();
        set_ent(1, 1'b0, 2'd2, 3'b000, 32'h400);
        set_ent(5, 1'b0, 2'd3, 3'b111, 32'h40F);
        probe("R5 lower wins deny", K_RD, P_S, 34'h1000, 1'b0, 1'b1, 3'd1);
        probe("R5 upper used elsewhere", K_RD, P_S, 34'h1010, 1'b1, 1'b1, 3'd5);
        probe("R6 machine exempt", K_WR, P_M, 34'h1000, 1'b1, 1'b1, 3'd1);
    endtask

    task automatic t_lock();
        clear_all();
        set_ent(6, 1'b0, 2'd2, 3'b001, 32'h800);
        probe("R6 unlocked M write", K_WR, P_M, 34'h2000, 1'b1, 1'b1, 3'd6);
        set_ent(6, 1'b1, 2'd2, 3'b001, 32'h800);
        probe("R7 locked M write", K_WR, P_M, 34'h2000, 1'b0, 1'b1, 3'd6);
        probe("R7 locked M read", K_RD, P_M, 34'h2000, 1'b1, 1'b1, 3'd6);
        probe("R8 bad kind M", K_BAD, P_M, 34'h2000, 1'b0, 1'b1, 3'd6);
        clear_all();
        probe("R8 bad kind all off", K_BAD, P_M, 34'h0, 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_all_off();
        t_na4();
        t_tor();
        t_napot();
        t_priority();
        t_lock();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule